// File: doc/BRIEF.md
# Cell-Level Bus Master Transmitter

This block is the transmit half of a single-port, 8-bit ATM cell bus master working in whole-cell mode. An upstream buffer holds cells. The buffer raises a ready flag whenever it holds at least one complete cell that has not yet been read. The buffer shows its head byte on a show-ahead read port and drops that byte when the block pulses a read strobe. The block starts a cell on its own when the slave's cell-available input is high and a complete cell is waiting. It then sends the cell byte by byte, driving an active-low enable, a start-of-cell flag, the data byte and a parity bit.

Near the end of each cell the block decides whether to send the next cell straight after it with no idle cycle. It samples cell-available together with the buffer's ready flag at one fixed point. A slave that cannot take another cell must therefore withdraw cell-available at least four cycles before the cell ends. The cell length comes from a static 8-bit input, which is clamped into the supported range. Parity is odd, and an enable input can turn it off.

Top module: `cellbus_tx`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, `tx_enb_n` is 1 and `tx_soc` is 0.
- R2: In idle, the block starts a cell at a rising edge only if `tx_clav` and `buf_cell_rdy` are both 1 at that edge. The first byte of the cell is on the bus from that edge onward. While either input is 0, `tx_enb_n` stays 1.
- R3: `tx_soc` is 1 for exactly one cycle per cell, together with the first byte and with `tx_enb_n` at 0.
- R4: Each cell has one byte for each cycle with `tx_enb_n` at 0, with no pause inside the cell. The bytes are the buffer bytes in the order they were read, and each read strobe pops exactly one byte.
- R5: The cell length is `cfg_cell_len` clamped to the range 16..128. A value below 16 gives 16 bytes, and a value above 128 gives 128 bytes.
- R6: The block samples `tx_clav` and `buf_cell_rdy` at the rising edge where the fourth-from-last byte of a cell is on the bus. If both are 1, the next cell's first byte, with `tx_soc` at 1, follows the last byte on the very next cycle, and `tx_enb_n` stays 0.
- R7: If `tx_clav` is 0 at that sample edge, `tx_enb_n` goes to 1 after the last byte. A change of `tx_clav` after that edge does not alter the chaining decision already taken.
- R8: If `buf_cell_rdy` is 0 at that sample edge, the block does not chain, even when a cell becomes ready before the current cell ends. The next cell then starts from idle after at least one cycle with `tx_enb_n` at 1.
- R9: With `cfg_par_en` at 1, the XOR of `tx_data` and `tx_par` is 1 (odd parity) on every byte. With `cfg_par_en` at 0, `tx_par` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cell_len | input | 8 | Static cell length in bytes, clamped to 16..128 |
| cfg_par_en | input | 1 | 1 = odd parity on `tx_par`, 0 = `tx_par` held at 0 |
| buf_cell_rdy | input | 1 | Buffer holds at least one complete, still unread cell |
| buf_data | input | 8 | Head byte of the show-ahead buffer |
| buf_rd | output | 1 | Pops the head byte at the rising edge |
| tx_clav | input | 1 | Slave can accept a whole cell |
| tx_enb_n | output | 1 | Active-low enable; 0 marks a valid byte |
| tx_soc | output | 1 | First byte of a cell |
| tx_data | output | 8 | Data byte |
| tx_par | output | 1 | Parity bit for `tx_data` |

## Verification
Every bus output passes through one register. A start decision taken at edge N therefore shows up as `tx_enb_n` low with `tx_soc` high in the half-cycle after edge N. A byte popped at edge N is on `tx_data` from that same edge. The bench changes its inputs and reads the outputs on falling edges, so each stimulus applied before edge N is checked just after it.

The slave model drops `tx_clav` on the falling edge when a chosen byte index is on the bus. With the index set to length−4, the drop lands just before the sample edge. With length−3 it lands just after it. This pins the chaining decision to the exact cycle.

The scoreboard records, for each first byte, whether the previous cycle was idle. Back-to-back and gapped cells are therefore told apart cycle by cycle.

// File: rtl/cbtx_pkg.sv
package cbtx_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } cbtx_state_e;
endpackage

// File: rtl/cbtx_len_clamp.sv
module cbtx_len_clamp #(
  parameter int LEN_W   = 8,
  parameter int MIN_LEN = 16,
  parameter int MAX_LEN = 128
) (
  input  logic [LEN_W-1:0] cfg_len,
  output logic [LEN_W-1:0] cell_len
);
  localparam logic [LEN_W-1:0] LO = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] HI = LEN_W'(MAX_LEN);

  always_comb begin
    if (cfg_len < LO)      cell_len = LO;
    else if (cfg_len > HI) cell_len = HI;
    else                   cell_len = cfg_len;
  end
endmodule

// File: rtl/cbtx_seq.sv
module cbtx_seq
  import cbtx_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int LOOKAHEAD = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] cell_len,
  input  logic             clav,
  input  logic             cell_rdy,
  output logic             drive,
  output logic             first
);
  localparam logic [LEN_W-1:0] SAMPLE_REM = LEN_W'(LOOKAHEAD - 1);

  cbtx_state_e      state_q;
  logic [LEN_W-1:0] rem_q;
  logic             chain_q;
  logic             start_idle, cont, chain_go;

  always_comb begin
    start_idle = (state_q == ST_IDLE) && clav && cell_rdy;
    cont       = (state_q == ST_SEND) && (rem_q != '0);
    chain_go   = (state_q == ST_SEND) && (rem_q == '0) && chain_q;
    first      = start_idle || chain_go;
    drive      = first || cont;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      chain_q <= 1'b0;
    end else if (first) begin
      state_q <= ST_SEND;
      rem_q   <= cell_len - LEN_W'(1);
      chain_q <= 1'b0;
    end else if (cont) begin
      rem_q <= rem_q - LEN_W'(1);
      if (rem_q == SAMPLE_REM) chain_q <= clav && cell_rdy;
    end else if (state_q == ST_SEND) begin
      state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/cbtx_out.sv
module cbtx_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drive,
  input  logic              first,
  input  logic [DATA_W-1:0] din,
  input  logic              par_en,
  output logic              enb_n,
  output logic              soc,
  output logic [DATA_W-1:0] data,
  output logic              par
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enb_n <= 1'b1;
      soc   <= 1'b0;
      data  <= '0;
      par   <= 1'b0;
    end else begin
      enb_n <= !drive;
      soc   <= first;
      if (drive) begin
        data <= din;
        par  <= par_en ? ~^din : 1'b0;
      end
    end
  end
endmodule

// File: rtl/cellbus_tx.sv
module cellbus_tx #(
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 8,
  parameter int MIN_LEN   = 16,
  parameter int MAX_LEN   = 128,
  parameter int LOOKAHEAD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_cell_len,
  input  logic              cfg_par_en,
  input  logic              buf_cell_rdy,
  input  logic [DATA_W-1:0] buf_data,
  output logic              buf_rd,
  input  logic              tx_clav,
  output logic              tx_enb_n,
  output logic              tx_soc,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_par
);
  logic [LEN_W-1:0] cell_len;
  logic             drive, first;

  cbtx_len_clamp #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_clamp (
    .cfg_len (cfg_cell_len),
    .cell_len(cell_len)
  );

  cbtx_seq #(.LEN_W(LEN_W), .LOOKAHEAD(LOOKAHEAD)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .cell_len(cell_len),
    .clav    (tx_clav),
    .cell_rdy(buf_cell_rdy),
    .drive   (drive),
    .first   (first)
  );

  cbtx_out #(.DATA_W(DATA_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .drive (drive),
    .first (first),
    .din   (buf_data),
    .par_en(cfg_par_en),
    .enb_n (tx_enb_n),
    .soc   (tx_soc),
    .data  (tx_data),
    .par   (tx_par)
  );

  assign buf_rd = drive;
endmodule

// File: rtl/cellbus_tx_chk.sv
module cellbus_tx_chk #(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 8,
  parameter int MIN_LEN = 16,
  parameter int MAX_LEN = 128
) (
  input logic              clk,
  input logic              rst,
  input logic [LEN_W-1:0]  cfg_cell_len,
  input logic              cfg_par_en,
  input logic              buf_cell_rdy,
  input logic [DATA_W-1:0] buf_data,
  input logic              buf_rd,
  input logic              tx_clav,
  input logic              tx_enb_n,
  input logic              tx_soc,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_par
);
  logic [LEN_W:0] exp_len;
  logic [LEN_W:0] seen_q;

  always_comb begin
    if (int'(cfg_cell_len) < MIN_LEN)      exp_len = (LEN_W+1)'(MIN_LEN);
    else if (int'(cfg_cell_len) > MAX_LEN) exp_len = (LEN_W+1)'(MAX_LEN);
    else                                   exp_len = {1'b0, cfg_cell_len};
  end

  always_ff @(posedge clk) begin
    if (rst)            seen_q <= '0;
    else if (!tx_enb_n) seen_q <= tx_soc ? (LEN_W+1)'(1) : seen_q + (LEN_W+1)'(1);
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_enb_n && !tx_soc)); // R1
  AST_START_NEEDS_CLAV: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_enb_n) |-> $past(tx_clav && buf_cell_rdy)); // R2
  AST_RD_GIVES_BYTE: assert property (@(posedge clk) disable iff (rst)
    buf_rd |=> !tx_enb_n); // R4
  AST_SOC_WITH_ENB: assert property (@(posedge clk) disable iff (rst)
    tx_soc |-> !tx_enb_n); // R3
  AST_SOC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tx_soc |=> !tx_soc); // R3
  AST_DATA_FROM_BUF: assert property (@(posedge clk) disable iff (rst)
    !tx_enb_n |-> (tx_data == $past(buf_data))); // R4
  AST_CELL_LEN_END: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_enb_n) |-> (seen_q == exp_len)); // R5
  AST_CELL_LEN_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (tx_soc && $past(!tx_enb_n)) |-> (seen_q == exp_len)); // R6
  AST_ODD_PARITY: assert property (@(posedge clk) disable iff (rst)
    (!tx_enb_n && cfg_par_en) |-> (^{tx_data, tx_par})); // R9
  AST_PARITY_OFF: assert property (@(posedge clk) disable iff (rst)
    (!tx_enb_n && !cfg_par_en) |-> !tx_par); // R9
endmodule

bind cellbus_tx cellbus_tx_chk #(
  .DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk(clk), .rst(rst), .cfg_cell_len(cfg_cell_len), .cfg_par_en(cfg_par_en),
  .buf_cell_rdy(buf_cell_rdy), .buf_data(buf_data), .buf_rd(buf_rd),
  .tx_clav(tx_clav), .tx_enb_n(tx_enb_n), .tx_soc(tx_soc),
  .tx_data(tx_data), .tx_par(tx_par)
);

// File: tb/cellbus_tx_test.sv
module cellbus_tx_test;
  localparam int PERIOD = 20;

  typedef struct {
    logic [7:0] d;
    logic       soc;
    logic       gap;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_len = 8'd20;
  logic       par_en = 1'b1;
  logic       clav = 1'b0;
  logic       rdy, brd, enb_n, soc, par;
  logic [7:0] bdata, data;
  logic [7:0] mem [0:2047];
  int wr_ptr = 0, rd_ptr = 0, blen = 20;
  int tests = 0, fails = 0, cycles = 0;
  int drop_idx = -1, load_idx = -1, idx = 0, bytes_seen = 0;
  logic prev_enb_n = 1'b1;
  item_t q[$];

  always #(PERIOD/2) clk = ~clk;

  assign rdy   = (wr_ptr / blen) > ((rd_ptr + blen - 1) / blen);
  assign bdata = mem[rd_ptr % 2048];

  cellbus_tx uut (
    .clk(clk), .rst(rst), .cfg_cell_len(cfg_len), .cfg_par_en(par_en),
    .buf_cell_rdy(rdy), .buf_data(bdata), .buf_rd(brd), .tx_clav(clav),
    .tx_enb_n(enb_n), .tx_soc(soc), .tx_data(data), .tx_par(par)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst)      rd_ptr <= 0;
    else if (brd) rd_ptr <= rd_ptr + 1;
  end

  function automatic int clamp_len(int c);
    if (c < 16)  return 16;
    if (c > 128) return 128;
    return c;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_cell(bit gap, string tag, logic [7:0] seed);
    for (int i = 0; i < blen; i++) begin
      logic [7:0] b;
      b = seed + 8'(i * 13);
      mem[wr_ptr % 2048] = b;
      wr_ptr++;
      q.push_back('{b, i == 0, gap, tag});
    end
  endtask

  // scoreboard monitor and reactive slave model
  always @(negedge clk) begin
    if (rst) begin
      prev_enb_n = 1'b1;
      idx = 0;
    end else begin
      if (!enb_n) begin
        bytes_seen++;
        if (q.size() == 0) begin
          chk(1'b0, "R4", "unexpected byte", data, 0);
        end else begin
          item_t e;
          e = q.pop_front();
          chk(data == e.d, "R4", "data", data, e.d);
          chk(soc == e.soc, "R3", "start flag", soc, e.soc);
          chk(par == (par_en ? ~^e.d : 1'b0), "R9", "parity", par, par_en ? ~^e.d : 1'b0);
          if (e.soc) chk(prev_enb_n == e.gap, e.tag, "idle before cell", prev_enb_n, e.gap);
        end
        idx = soc ? 0 : idx + 1;
        if (idx == drop_idx) begin
          clav = 1'b0;
          drop_idx = -1;
        end
        if (idx == load_idx) begin
          load_idx = -1;
          push_cell(1'b1, "R8", 8'h5A);
        end
      end
      prev_enb_n = enb_n;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    clav = 1'b0;
    blen = clamp_len(int'(cfg_len));
    wr_ptr = 0;
    drop_idx = -1;
    load_idx = -1;
    bytes_seen = 0;
    q.delete();
    repeat (3) @(negedge clk);
    chk(enb_n && !soc, "R1", "outputs in reset", {enb_n, soc}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    chk(enb_n && !soc, "R1", "outputs after reset", {enb_n, soc}, 2'b10);
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      if (q.size() == 0 && enb_n) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R4", "bytes outstanding", q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;

    // start only with clav and a ready cell
    cfg_len = 8'd20; par_en = 1'b1;
    do_reset();
    push_cell(1'b1, "R2", 8'h11);
    begin
      bit quiet;
      quiet = 1'b1;
      repeat (10) begin
        @(negedge clk);
        if (!enb_n) quiet = 1'b0;
      end
      chk(quiet, "R2", "idle while clav low", !quiet, 0);
    end
    clav = 1'b1;
    @(negedge clk);
    chk(!enb_n && soc, "R2", "first byte one edge after clav", {enb_n, soc}, 2'b01);
    drain();

    // back-to-back chaining at minimum length
    cfg_len = 8'd16;
    do_reset();
    push_cell(1'b1, "R2", 8'h20);
    push_cell(1'b0, "R6", 8'h37);
    push_cell(1'b0, "R6", 8'h4C);
    clav = 1'b1;
    drain();

    // clav withdrawn just before the sample edge
    cfg_len = 8'd24;
    do_reset();
    push_cell(1'b1, "R2", 8'h61);
    push_cell(1'b1, "R7", 8'h72);
    drop_idx = blen - 4;
    clav = 1'b1;
    for (int i = 0; i < 500; i++) begin
      if (q.size() == blen && enb_n) break;
      @(negedge clk);
    end
    begin
      bit quiet;
      quiet = 1'b1;
      repeat (8) begin
        @(negedge clk);
        if (!enb_n) quiet = 1'b0;
      end
      chk(quiet, "R7", "no chain after early clav drop", !quiet, 0);
    end
    clav = 1'b1;
    drain();

    // clav withdrawn after the sample edge: chain still taken
    cfg_len = 8'd24;
    do_reset();
    push_cell(1'b1, "R2", 8'h83);
    push_cell(1'b0, "R7", 8'h94);
    drop_idx = blen - 3;
    clav = 1'b1;
    drain();
    chk(bytes_seen == 2 * blen, "R7", "bytes after late drop", bytes_seen, 2 * blen);

    // next cell arrives after the sample edge
    cfg_len = 8'd16;
    do_reset();
    push_cell(1'b1, "R2", 8'hA5);
    load_idx = blen - 2;
    clav = 1'b1;
    drain();
    chk(bytes_seen == 2 * blen, "R8", "late cell sent", bytes_seen, 2 * blen);

    // clamp below range, parity off
    cfg_len = 8'd5; par_en = 1'b0;
    do_reset();
    push_cell(1'b1, "R2", 8'hB6);
    push_cell(1'b0, "R6", 8'hC7);
    clav = 1'b1;
    drain();
    chk(bytes_seen == 32, "R5", "length clamp low", bytes_seen, 32);

    // clamp above range
    cfg_len = 8'd200; par_en = 1'b1;
    do_reset();
    push_cell(1'b1, "R2", 8'hD8);
    clav = 1'b1;
    drain();
    chk(bytes_seen == 128, "R5", "length clamp high", bytes_seen, 128);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    while (cycles < 200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired act=%0d exp=0", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule